// File: doc/BRIEF.md
# Dual Compare 8-Bit Timer

This block is an up-counter with two compare registers. Each time the counter steps onto the value held in a compare register, that channel raises a match event. The event drives one timer output pin through an action that software programs for that channel: hold, drive low, drive high or invert. The counter can also be returned to zero by either match, or by a rising edge on an asynchronous external clear input. A clear-source field selects which of these applies.

Software loads the two compare values and a control word through a simple write port. A count-enable tick from an upstream prescaler sets the counting rate. The counter value is also brought out, so that neighbouring logic and the bench can observe it.

Top module: `dual_cmp_timer`

## Requirements
- R1: While `tick` is low and no clear event occurs, `count_o` keeps its value.
- R2: Each clock edge with `tick` high and no clear event adds one to `count_o`, and 0xFF wraps to 0x00.
- R3: A match event on channel A occurs in a cycle where `count_o` equals compare A and the counter was loaded (advanced or cleared) on the previous edge. On the next edge, the channel A action (control bits [1:0]) sets `tmr_out`: 0 keeps it, 1 drives 0, 2 drives 1, 3 inverts it.
- R4: Channel B has the same match rule against compare B, and its own action field (control bits [3:2]) with the same encoding.
- R5: With clear select (control bits [5:4]) equal to 1 or 2, a match on A or on B, respectively, puts `count_o` to 0 on the following edge. A clear takes priority over `tick`. Select 0 never clears.
- R6: With clear select 3, `ext_clr` passes through a two-flop synchronizer. A rising edge clears the counter on the third clock edge after the input rises, provided the input stays high for at least two cycles. Holding the input high gives no further clears, and with any other select the input has no effect on `count_o`.
- R7: When both channels match in the same cycle, the resulting action is chosen by priority: drive 0 beats drive 1, drive 1 beats invert, and invert beats keep.
- R8: A write that loads a compare register with the current count, while the counter is not moving, produces no match event. `tmr_out` stays unchanged.
- R9: The synchronous reset `rst` sets `count_o` to 0, `tmr_out` to 0, both compare registers to 0 and the control word to 0.
- R10: With `wr_en` high, `wr_addr` 0 loads compare A, 1 loads compare B, 2 loads the control word, and 3 is ignored. Each write takes effect at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select for a write |
| wr_data | input | W | Write data |
| tick | input | 1 | Count-enable pulse |
| ext_clr | input | 1 | Asynchronous external clear request, rising-edge active |
| count_o | output | W | Current counter value |
| tmr_out | output | 1 | Registered timer output level |

## Verification
The assertions assume that `rst` is high from time zero until the first edges have passed. They also assume that an `ext_clr` pulse lasts at least two clock cycles, so that the synchronizer always sees it. The random stimulus keeps every level of `ext_clr` for two to four cycles and keeps compare values small, so that matches, clears and the self-clearing case with compare value 0 occur often. Directed sequences cover wrap, priority between the channels, writes that hit the current count, and the external clear both while it is selected and while it is not.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_FLIP = 2'd3
  } act_e;

  typedef enum logic [1:0] {
    CSRC_NONE = 2'd0,
    CSRC_A    = 2'd1,
    CSRC_B    = 2'd2,
    CSRC_EXT  = 2'd3
  } csrc_e;

  localparam logic [1:0] ADDR_CMP_A = 2'd0;
  localparam logic [1:0] ADDR_CMP_B = 2'd1;
  localparam logic [1:0] ADDR_CTL   = 2'd2;

  localparam int CTL_ACT_A_LSB = 0;
  localparam int CTL_ACT_B_LSB = 2;
  localparam int CTL_CSRC_LSB  = 4;
  localparam int CTL_BITS      = 6;

  localparam int N_CHAN = 2;

endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [1:0]           wr_addr,
  input  logic [W-1:0]         wr_data,
  output logic [N_CHAN-1:0][W-1:0] cmp_val,
  output act_e                 act_a,
  output act_e                 act_b,
  output csrc_e                csrc
);

  logic [CTL_BITS-1:0] ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmp_val <= '0;
      ctl_q   <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADDR_CMP_A: cmp_val[0] <= wr_data;
        ADDR_CMP_B: cmp_val[1] <= wr_data;
        ADDR_CTL:   ctl_q      <= wr_data[CTL_BITS-1:0];
        default:    ;
      endcase
    end
  end

  assign act_a = act_e'(ctl_q[CTL_ACT_A_LSB +: 2]);
  assign act_b = act_e'(ctl_q[CTL_ACT_B_LSB +: 2]);
  assign csrc  = csrc_e'(ctl_q[CTL_CSRC_LSB +: 2]);

endmodule

// File: rtl/tmr_sync_edge.sv
module tmr_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);

  localparam int LAST = STAGES;

  logic [LAST:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[LAST-1:0], din};
  end

  assign rise = chain_q[LAST-1] & ~chain_q[LAST];

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         fresh
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      fresh <= 1'b0;
    end else begin
      if (clr)       cnt <= '0;
      else if (tick) cnt <= cnt + W'(1);
      fresh <= clr | tick;
    end
  end

endmodule

// File: rtl/tmr_cmp.sv
module tmr_cmp #(
  parameter int W = 8
) (
  input  logic [W-1:0] cnt,
  input  logic         fresh,
  input  logic [W-1:0] ref_val,
  output logic         hit
);

  assign hit = fresh && (cnt == ref_val);

endmodule

// File: rtl/tmr_out_ctl.sv
module tmr_out_ctl
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hit_a,
  input  logic hit_b,
  input  act_e act_a,
  input  act_e act_b,
  output logic level
);

  logic want_low, want_high, want_flip;
  logic level_d;

  always_comb begin
    want_low  = (hit_a && act_a == ACT_LOW)  || (hit_b && act_b == ACT_LOW);
    want_high = (hit_a && act_a == ACT_HIGH) || (hit_b && act_b == ACT_HIGH);
    want_flip = (hit_a && act_a == ACT_FLIP) || (hit_b && act_b == ACT_FLIP);
    if (want_low)       level_d = 1'b0;
    else if (want_high) level_d = 1'b1;
    else if (want_flip) level_d = ~level;
    else                level_d = level;
  end

  always_ff @(posedge clk) begin
    if (rst) level <= 1'b0;
    else     level <= level_d;
  end

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import tmr_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         tick,
  input  logic         ext_clr,
  output logic [W-1:0] count_o,
  output logic         tmr_out
);

  logic [N_CHAN-1:0][W-1:0] cmp_val;
  logic [N_CHAN-1:0]        match;
  act_e                     act_a, act_b;
  csrc_e                    csrc;
  logic                     ext_rise;
  logic                     clr_evt;
  logic                     fresh;

  tmr_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .cmp_val (cmp_val),
    .act_a   (act_a),
    .act_b   (act_b),
    .csrc    (csrc)
  );

  tmr_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (ext_clr),
    .rise (ext_rise)
  );

  always_comb begin
    unique case (csrc)
      CSRC_A:   clr_evt = match[0];
      CSRC_B:   clr_evt = match[1];
      CSRC_EXT: clr_evt = ext_rise;
      default:  clr_evt = 1'b0;
    endcase
  end

  tmr_counter #(.W(W)) u_cnt (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick),
    .clr   (clr_evt),
    .cnt   (count_o),
    .fresh (fresh)
  );

  for (genvar ch = 0; ch < N_CHAN; ch++) begin : g_chan
    tmr_cmp #(.W(W)) u_cmp (
      .cnt     (count_o),
      .fresh   (fresh),
      .ref_val (cmp_val[ch]),
      .hit     (match[ch])
    );
  end

  tmr_out_ctl u_out (
    .clk   (clk),
    .rst   (rst),
    .hit_a (match[0]),
    .hit_b (match[1]),
    .act_a (act_a),
    .act_b (act_b),
    .level (tmr_out)
  );

endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [W-1:0] count_o,
  input logic         tmr_out,
  input logic         clr_evt,
  input logic         ext_rise,
  input logic         match_a,
  input logic         match_b,
  input logic [1:0]   act_a,
  input logic [1:0]   act_b
);

  // R1
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr_evt) |=> $stable(count_o));

  // R2
  a_r2_step_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr_evt) |=> (count_o == W'($past(count_o) + W'(1))));

  // R5 and R6: any clear event zeroes the counter
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr_evt |=> (count_o == '0));

  // R6: one rising edge gives a single-cycle event
  a_r6_single_edge: assert property (@(posedge clk) disable iff (rst)
    ext_rise |=> !ext_rise);

  // R3
  a_r3_set_on_a: assert property (@(posedge clk) disable iff (rst)
    (match_a && !match_b && act_a == 2'd2) |=> tmr_out);

  // R4
  a_r4_low_on_b: assert property (@(posedge clk) disable iff (rst)
    (match_b && !match_a && act_b == 2'd1) |=> !tmr_out);

  // R7
  a_r7_low_wins: assert property (@(posedge clk) disable iff (rst)
    (match_a && match_b && (act_a == 2'd1 || act_b == 2'd1)) |=> !tmr_out);

  // R8: without a match event the output never moves
  a_r8_quiet_out: assert property (@(posedge clk) disable iff (rst)
    (!match_a && !match_b) |=> $stable(tmr_out));

endmodule

bind dual_cmp_timer tmr_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .count_o  (count_o),
  .tmr_out  (tmr_out),
  .clr_evt  (clr_evt),
  .ext_rise (ext_rise),
  .match_a  (match[0]),
  .match_b  (match[1]),
  .act_a    (act_a),
  .act_b    (act_b)
);

// File: tb/test_dual_cmp_timer.sv
module test_dual_cmp_timer;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         tick = 1'b0;
  logic         ext_clr = 1'b0;
  logic [W-1:0] count_o;
  logic         tmr_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dual_cmp_timer #(.W(W)) i_dual_cmp_timer (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .tick    (tick),
    .ext_clr (ext_clr),
    .count_o (count_o),
    .tmr_out (tmr_out)
  );

  // ---------------- reference model ----------------
  logic [W-1:0] m_cnt, m_ca, m_cb;
  logic [5:0]   m_ctl;
  logic         m_fresh, m_out, m_s1, m_s2, m_s3;

  function automatic logic ref_level(logic cur, logic ma, logic mb,
                                     logic [1:0] aa, logic [1:0] ab);
    logic lo, hi, fl;
    lo = (ma && aa == 2'd1) || (mb && ab == 2'd1);
    hi = (ma && aa == 2'd2) || (mb && ab == 2'd2);
    fl = (ma && aa == 2'd3) || (mb && ab == 2'd3);
    if (lo) return 1'b0;
    if (hi) return 1'b1;
    if (fl) return ~cur;
    return cur;
  endfunction

  always @(posedge clk) begin
    logic ma, mb, rise, clr;
    if (rst) begin
      m_cnt = '0; m_ca = '0; m_cb = '0; m_ctl = '0;
      m_fresh = 1'b0; m_out = 1'b0; m_s1 = 1'b0; m_s2 = 1'b0; m_s3 = 1'b0;
    end else begin
      ma   = m_fresh && (m_cnt == m_ca);
      mb   = m_fresh && (m_cnt == m_cb);
      rise = m_s2 && !m_s3;
      case (m_ctl[5:4])
        2'd1:    clr = ma;
        2'd2:    clr = mb;
        2'd3:    clr = rise;
        default: clr = 1'b0;
      endcase
      m_out = ref_level(m_out, ma, mb, m_ctl[1:0], m_ctl[3:2]);
      if (clr)       m_cnt = '0;
      else if (tick) m_cnt = m_cnt + 8'd1;
      m_fresh = clr || tick;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_clr;
      if (wr_en) begin
        case (wr_addr)
          2'd0: m_ca = wr_data;
          2'd1: m_cb = wr_data;
          2'd2: m_ctl = wr_data[5:0];
          default: ;
        endcase
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one clock edge, then compare against the model (R1 R2 R3 R4 R5 R6 R7 R10)
  task automatic cyc();
    @(posedge clk);
    #2;
    check("R2/R5/R6 model count", count_o, m_cnt);
    check("R3/R4/R7 model output", {7'd0, tmr_out}, {7'd0, m_out});
  endtask

  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; tick = 1'b0; ext_clr = 1'b0; wr_en = 1'b0;
    cyc(); cyc();
    rst = 1'b0;
  endtask

  task automatic run_to(logic [W-1:0] v);
    for (int i = 0; i < 600 && count_o != v; i++) cyc();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [W-1:0] v;
    int hold;
    void'($urandom(32'd4242));

    // R9 reset state
    do_reset();
    check("R9 count after reset", count_o, 8'h00);
    check("R9 out after reset", {7'd0, tmr_out}, 8'h00);

    // R1 no tick, no movement
    for (int i = 0; i < 5; i++) cyc();
    check("R1 idle count", count_o, 8'h00);

    // R2 wrap
    tick = 1'b1;
    for (int i = 0; i < 255; i++) cyc();
    check("R2 reach FF", count_o, 8'hFF);
    cyc();
    check("R2 wrap to 00", count_o, 8'h00);

    // R3 toggle on A, R10 addr 0 and 2
    do_reset();
    wr(2'd2, 8'h03);
    wr(2'd0, 8'd3);
    tick = 1'b1;
    run_to(8'd3);
    check("R3 before action", {7'd0, tmr_out}, 8'h00);
    cyc();
    check("R3 toggle count", count_o, 8'd4);
    check("R3 toggled", {7'd0, tmr_out}, 8'h01);

    // R4 drive high then low on B, R10 addr 1 and ignored addr 3
    do_reset();
    wr(2'd2, 8'h08);
    wr(2'd1, 8'd2);
    wr(2'd3, 8'h30);
    tick = 1'b1;
    run_to(8'd3);
    check("R4 set on B", {7'd0, tmr_out}, 8'h01);
    wr(2'd2, 8'h04);
    run_to(8'd3);
    check("R4 low on B", {7'd0, tmr_out}, 8'h00);
    check("R10 addr 3 ignored: no ext select", count_o, 8'd3);

    // R5 clear on A, clear beats tick
    do_reset();
    wr(2'd2, 8'h10);
    wr(2'd0, 8'd5);
    tick = 1'b1;
    run_to(8'd5);
    cyc();
    check("R5 clear on A", count_o, 8'd0);
    // clear on B
    wr(2'd2, 8'h20);
    wr(2'd1, 8'd9);
    run_to(8'd9);
    cyc();
    check("R5 clear on B", count_o, 8'd0);

    // R6 external edge
    do_reset();
    wr(2'd2, 8'h30);
    tick = 1'b1;
    run_to(8'd7);
    tick = 1'b0;
    ext_clr = 1'b1;
    cyc();
    check("R6 edge 1", count_o, 8'd7);
    cyc();
    check("R6 edge 2", count_o, 8'd7);
    cyc();
    check("R6 cleared at edge 3", count_o, 8'd0);
    tick = 1'b1;
    cyc(); cyc(); cyc();
    check("R6 level held no reclear", count_o, 8'd3);
    tick = 1'b0;
    ext_clr = 1'b0;
    wr(2'd2, 8'h00);
    cyc(); cyc(); cyc();
    v = count_o;
    ext_clr = 1'b1;
    cyc(); cyc(); cyc();
    ext_clr = 1'b0;
    cyc(); cyc();
    check("R6 ignored when not selected", count_o, v);

    // R7 priority
    do_reset();
    wr(2'd0, 8'd4);
    wr(2'd1, 8'd4);
    wr(2'd2, 8'h02);
    tick = 1'b1;
    run_to(8'd4); cyc();
    check("R7 set alone", {7'd0, tmr_out}, 8'h01);
    wr(2'd2, 8'h0B);
    run_to(8'd4); cyc();
    check("R7 high beats flip", {7'd0, tmr_out}, 8'h01);
    wr(2'd2, 8'h09);
    run_to(8'd4); cyc();
    check("R7 low beats high", {7'd0, tmr_out}, 8'h00);
    wr(2'd2, 8'h03);
    run_to(8'd4); cyc();
    check("R7 flip beats keep", {7'd0, tmr_out}, 8'h01);

    // R8 write hitting current count
    do_reset();
    wr(2'd2, 8'h02);
    tick = 1'b1;
    cyc(); cyc(); cyc();
    tick = 1'b0;
    cyc(); cyc();
    v = count_o;
    wr(2'd0, v);
    for (int i = 0; i < 5; i++) cyc();
    check("R8 no match from write", {7'd0, tmr_out}, 8'h00);
    check("R8 count still", count_o, v);

    // random phase
    do_reset();
    hold = 0;
    for (int i = 0; i < 4000; i++) begin
      tick = ($urandom % 10) < 7;
      if (hold == 0) begin
        if (($urandom % 8) == 0) ext_clr = ~ext_clr;
        hold = 2 + ($urandom % 3);
      end
      hold--;
      if (($urandom % 7) == 0) begin
        wr_en   = 1'b1;
        wr_addr = 2'($urandom % 4);
        wr_data = (wr_addr == 2'd2) ? 8'($urandom % 64) : 8'($urandom % 32);
      end else begin
        wr_en = 1'b0;
      end
      cyc();
    end
    wr_en = 1'b0;

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule